// File: doc/BRIEF.md
# Voltage-Setting Register Target on a Two-Wire Serial Bus

This block is a serial-bus target with a fixed 7-bit address of 0x40. It gives a host controller access to a small set of supply-control registers: two output-voltage code registers, a control register and a status register. The target samples SCL and SDA with a faster system clock. It recognises START, repeated START and STOP conditions. It acknowledges its own address and serves two kinds of transaction. A single-register write sends a register byte and then one data byte. A read first loads the register pointer with a write phase, then issues a repeated START and a read address, and returns one byte.

The three writable registers drive ports so that the surrounding supply logic can use them. Two event inputs from outside set sticky flags in the status register. A read of the status register returns the flags and then clears them. SDA is driven only through an open-drain enable: when the enable is high, the line is pulled low.

Top module: `vreg_i2c_target`

## Requirements
- R1: After reset, the first voltage code is 0x10, the second voltage code is 0x38, the control register is 0x6B, both status flags are clear and the SDA pull-down is released.
- R2: The target acknowledges only when the address byte carries address 0x40. It pulls SDA low for the whole high phase of the ninth clock. Any other address gets no acknowledge, and the bytes that follow have no effect. The SDA enable changes only while SCL is low, except when it is released at a START or a STOP.
- R3: A write is START, 0x80, a register byte, a data byte, then STOP. The target acknowledges each of the three bytes.
- R4: A read is START, 0x80, a register byte, repeated START, 0x81, then one data byte sent MSB first. Only bits [2:0] of the register byte select the register, so 0x09 reaches the same register as 0x01.
- R5: A written value reaches its register at the SCL falling edge that ends the acknowledge after the data byte, and not earlier.
- R6: A read of index 0, 4, 6 or 7 returns 0x00. A write to one of those indices, or to the status index 5, changes nothing.
- R7: In the status register at index 5, bit 4 latches the thermal event input and bit 2 latches the power-bad event input. The other bits read 0. A flag stays set until the status register is read, and that read clears it. An event in the same cycle as the clearing read leaves the flag set.
- R8: Bit 7 of the control register at index 3 always reads 0. Writing the control register with bit 7 set returns all registers to their R1 values and clears the status flags.
- R9: A STOP sends the target back to idle with SDA released. A byte clocked after a STOP without a new START gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | Pulls SDA low while high |
| therm_evt_i | input | 1 | Thermal event, sets status bit 4 |
| pgbad_evt_i | input | 1 | Power-bad event, sets status bit 2 |
| vout_a_o | output | 8 | First output-voltage code register (index 1) |
| vout_b_o | output | 8 | Second output-voltage code register (index 2) |
| ctrl_o | output | 8 | Control register (index 3) |

## Verification
The assertions assume a single controller on the bus. They also assume that SDA holds steady while SCL is high, except for START and STOP, and that every SCL phase lasts well beyond the synchronizer delay, so an edge seen on SCL is never mixed up with a START or STOP. The bench controller drives a quarter bit period of ten system clocks and moves SDA only in the middle of the SCL low phase. It pulses the event inputs only between transactions, so a flag edge never overlaps a read whose result is being predicted.

// File: rtl/vreg_i2c_pkg.sv
package vreg_i2c_pkg;

    localparam int BYTE_W   = 8;
    localparam int IDX_W    = 3;
    localparam int N_EVT    = 2;

    localparam logic [6:0] TARGET_ADDR = 7'h40;

    localparam logic [IDX_W-1:0] IDX_VA   = 3'd1;
    localparam logic [IDX_W-1:0] IDX_VB   = 3'd2;
    localparam logic [IDX_W-1:0] IDX_CTRL = 3'd3;
    localparam logic [IDX_W-1:0] IDX_STAT = 3'd5;

    localparam logic [BYTE_W-1:0] RST_VA   = 8'h10;
    localparam logic [BYTE_W-1:0] RST_VB   = 8'h38;
    localparam logic [BYTE_W-1:0] RST_CTRL = 8'h6B;

    localparam int CTRL_SWRST_BIT = 7;
    localparam int STAT_THERM_BIT = 4;
    localparam int STAT_PGBAD_BIT = 2;

    typedef enum logic [3:0] {
        PH_IDLE, PH_ADDR, PH_ADDR_ACK, PH_PTR, PH_PTR_ACK,
        PH_WDAT, PH_WDAT_ACK, PH_RDAT, PH_RDAT_ACK, PH_PARK
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } reg_req_t;

    // flags vector: [1] thermal, [0] power-bad
    function automatic logic [BYTE_W-1:0] stat_byte(logic [N_EVT-1:0] flags);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[STAT_THERM_BIT] = flags[1];
        b[STAT_PGBAD_BIT] = flags[0];
        return b;
    endfunction

endpackage

// File: rtl/vreg_line_sync.sv
module vreg_line_sync
    import vreg_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] scl_pipe, sda_pipe;
    logic         scl_d, sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[MSB-1:0], scl_i};
            sda_pipe <= {sda_pipe[MSB-1:0], sda_i};
            scl_d    <= scl_pipe[MSB];
            sda_d    <= sda_pipe[MSB];
        end
    end

    always_comb begin
        ev_o.scl      = scl_pipe[MSB];
        ev_o.sda      = sda_pipe[MSB];
        ev_o.scl_rise = scl_pipe[MSB] & ~scl_d;
        ev_o.scl_fall = ~scl_pipe[MSB] & scl_d;
        ev_o.start    = scl_pipe[MSB] & scl_d & sda_d & ~sda_pipe[MSB];
        ev_o.stop     = scl_pipe[MSB] & scl_d & ~sda_d & sda_pipe[MSB];
    end

endmodule

// File: rtl/vreg_i2c_engine.sv
module vreg_i2c_engine
    import vreg_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic [BYTE_W-1:0] rd_data,
    output reg_req_t          req,
    output logic              sda_oe_o
);
    localparam logic [3:0] FULL = 4'(BYTE_W);

    phase_e            ph;
    logic [3:0]        nbits;
    logic [BYTE_W-1:0] shreg;
    logic [IDX_W-1:0]  ptr;
    logic              rw;
    logic              oe_q;

    assign sda_oe_o = oe_q;

    always_comb begin
        req.idx  = ptr;
        req.data = shreg;
        req.wr   = (ph == PH_WDAT_ACK) && ev.scl_fall;
        req.rd   = (ph == PH_ADDR_ACK) && ev.scl_fall && rw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            nbits <= '0;
            shreg <= '0;
            ptr   <= '0;
            rw    <= 1'b0;
            oe_q  <= 1'b0;
        end else if (ev.start) begin
            ph    <= PH_ADDR;
            nbits <= '0;
            oe_q  <= 1'b0;
        end else if (ev.stop) begin
            ph    <= PH_IDLE;
            nbits <= '0;
            oe_q  <= 1'b0;
        end else begin
            case (ph)
                PH_ADDR, PH_PTR, PH_WDAT: begin
                    if (ev.scl_rise && nbits < FULL) begin
                        shreg <= {shreg[BYTE_W-2:0], ev.sda};
                        nbits <= nbits + 4'd1;
                    end else if (ev.scl_fall && nbits == FULL) begin
                        nbits <= '0;
                        if (ph == PH_ADDR) begin
                            if (shreg[BYTE_W-1:1] == TARGET_ADDR) begin
                                rw   <= shreg[0];
                                oe_q <= 1'b1;
                                ph   <= PH_ADDR_ACK;
                            end else begin
                                ph   <= PH_PARK;
                            end
                        end else if (ph == PH_PTR) begin
                            ptr  <= shreg[IDX_W-1:0];
                            oe_q <= 1'b1;
                            ph   <= PH_PTR_ACK;
                        end else begin
                            oe_q <= 1'b1;
                            ph   <= PH_WDAT_ACK;
                        end
                    end
                end
                PH_ADDR_ACK: begin
                    if (ev.scl_fall) begin
                        nbits <= '0;
                        if (rw) begin
                            shreg <= rd_data;
                            oe_q  <= ~rd_data[BYTE_W-1];
                            ph    <= PH_RDAT;
                        end else begin
                            oe_q  <= 1'b0;
                            ph    <= PH_PTR;
                        end
                    end
                end
                PH_PTR_ACK: begin
                    if (ev.scl_fall) begin
                        oe_q <= 1'b0;
                        ph   <= PH_WDAT;
                    end
                end
                PH_WDAT_ACK: begin
                    if (ev.scl_fall) begin
                        oe_q <= 1'b0;
                        ph   <= PH_PARK;
                    end
                end
                PH_RDAT: begin
                    if (ev.scl_rise) begin
                        nbits <= nbits + 4'd1;
                    end else if (ev.scl_fall) begin
                        if (nbits == FULL) begin
                            oe_q <= 1'b0;
                            ph   <= PH_RDAT_ACK;
                        end else begin
                            shreg <= {shreg[BYTE_W-2:0], 1'b0};
                            oe_q  <= ~shreg[BYTE_W-2];
                        end
                    end
                end
                PH_RDAT_ACK: begin
                    if (ev.scl_fall) ph <= PH_PARK;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/vreg_regfile.sv
module vreg_regfile
    import vreg_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req,
    input  logic              therm_evt_i,
    input  logic              pgbad_evt_i,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] va_o,
    output logic [BYTE_W-1:0] vb_o,
    output logic [BYTE_W-1:0] ctrl_o
);
    logic              soft_rst;
    logic              flag_clr;
    logic [N_EVT-1:0]  evt_in;
    logic [N_EVT-1:0]  evt_q;

    assign soft_rst = req.wr && (req.idx == IDX_CTRL) && req.data[CTRL_SWRST_BIT];
    assign flag_clr = soft_rst || (req.rd && (req.idx == IDX_STAT));
    assign evt_in   = {therm_evt_i, pgbad_evt_i};

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            va_o   <= RST_VA;
            vb_o   <= RST_VB;
            ctrl_o <= RST_CTRL;
        end else if (req.wr) begin
            case (req.idx)
                IDX_VA:   va_o   <= req.data;
                IDX_VB:   vb_o   <= req.data;
                IDX_CTRL: ctrl_o <= {1'b0, req.data[BYTE_W-2:0]};
                default:  ;
            endcase
        end
    end

    for (genvar g = 0; g < N_EVT; g++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (rst) flag_q <= 1'b0;
            else     flag_q <= evt_in[g] | (flag_q & ~flag_clr);
        end
        assign evt_q[g] = flag_q;
    end

    always_comb begin
        case (req.idx)
            IDX_VA:   rd_data = va_o;
            IDX_VB:   rd_data = vb_o;
            IDX_CTRL: rd_data = ctrl_o;
            IDX_STAT: rd_data = stat_byte(evt_q);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/vreg_i2c_target.sv
module vreg_i2c_target
    import vreg_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic       therm_evt_i,
    input  logic       pgbad_evt_i,
    output logic [7:0] vout_a_o,
    output logic [7:0] vout_b_o,
    output logic [7:0] ctrl_o
);
    line_ev_t          ev;
    reg_req_t          req;
    logic [BYTE_W-1:0] rd_data;

    vreg_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    vreg_i2c_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .rd_data  (rd_data),
        .req      (req),
        .sda_oe_o (sda_oe_o)
    );

    vreg_regfile u_regs (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .therm_evt_i (therm_evt_i),
        .pgbad_evt_i (pgbad_evt_i),
        .rd_data     (rd_data),
        .va_o        (vout_a_o),
        .vb_o        (vout_b_o),
        .ctrl_o      (ctrl_o)
    );

endmodule

// File: rtl/vreg_i2c_target_chk.sv
module vreg_i2c_target_chk
    import vreg_i2c_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input line_ev_t   ev,
    input reg_req_t   req,
    input logic [7:0] rd_data,
    input logic       sda_oe_o,
    input logic       therm_evt_i,
    input logic       pgbad_evt_i,
    input logic [7:0] vout_a_o,
    input logic [7:0] vout_b_o,
    input logic [7:0] ctrl_o
);
    // R2: the pull-down moves only in SCL low, or on release at START/STOP
    p_sda_moves_low_r2: assert property (@(posedge clk) disable iff (rst)
        $changed(sda_oe_o) |-> (!ev.scl || $past(ev.start || ev.stop)));

    // R5: register outputs change only right after a seen SCL fall
    p_commit_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        ($changed(vout_a_o) || $changed(vout_b_o) || $changed(ctrl_o)) |-> $past(ev.scl_fall));

    // R7: an event is visible in the status byte on the next cycle
    p_therm_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        therm_evt_i |=> (req.idx != IDX_STAT || rd_data[STAT_THERM_BIT]));

    p_pgbad_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        pgbad_evt_i |=> (req.idx != IDX_STAT || rd_data[STAT_PGBAD_BIT]));

    // R7: unused status bits read zero
    p_stat_resv_r7: assert property (@(posedge clk) disable iff (rst)
        (req.idx == IDX_STAT) |-> (rd_data[7:5] == 3'b0 && !rd_data[3] && rd_data[1:0] == 2'b0));

    // R8: control write with bit 7 restores defaults
    p_soft_reset_r8: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.idx == IDX_CTRL && req.data[7]) |=>
        (vout_a_o == RST_VA && vout_b_o == RST_VB && ctrl_o == RST_CTRL));

    // R9: a STOP leaves SDA released
    p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
        $past(ev.stop) |-> !sda_oe_o);

endmodule

bind vreg_i2c_target vreg_i2c_target_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ev          (ev),
    .req         (req),
    .rd_data     (rd_data),
    .sda_oe_o    (sda_oe_o),
    .therm_evt_i (therm_evt_i),
    .pgbad_evt_i (pgbad_evt_i),
    .vout_a_o    (vout_a_o),
    .vout_b_o    (vout_b_o),
    .ctrl_o      (ctrl_o)
);

// File: tb/vreg_i2c_target_bench.sv
module vreg_i2c_target_bench;

    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic therm = 1'b0;
    logic pgbad = 1'b0;
    logic sda_oe;
    logic [7:0] va, vb, ctrl;
    wire  sda_line = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] m_va, m_vb, m_ctrl;
    logic       m_th, m_pg;

    always #5 clk = ~clk;

    vreg_i2c_target u_vreg_i2c_target (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .therm_evt_i(therm), .pgbad_evt_i(pgbad),
        .vout_a_o(va), .vout_b_o(vb), .ctrl_o(ctrl)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic m_defaults();
        m_va = 8'h10; m_vb = 8'h38; m_ctrl = 8'h6B; m_th = 1'b0; m_pg = 1'b0;
    endtask

    task automatic m_write(input logic [7:0] rb, input logic [7:0] d);
        case (rb[2:0])
            3'd1: m_va = d;
            3'd2: m_vb = d;
            3'd3: if (d[7]) m_defaults(); else m_ctrl = {1'b0, d[6:0]};
            default: ;
        endcase
    endtask

    function automatic logic [7:0] m_peek(input logic [7:0] rb);
        case (rb[2:0])
            3'd1: return m_va;
            3'd2: return m_vb;
            3'd3: return m_ctrl;
            3'd5: return {3'b0, m_th, 1'b0, m_pg, 2'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q(); scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(); scl_m = 1'b1; wait_q(); sda_m = 1'b1; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q(); scl_m = 1'b1; wait_q(); wait_q(); scl_m = 1'b0; wait_q();
        end
        sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
        acked = ~sda_line;
        wait_q(); scl_m = 1'b0; wait_q();
    endtask

    // data byte whose ACK is watched for the commit point (R5)
    task automatic send_probe(input logic [7:0] b, input logic [7:0] old_v);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_q(); scl_m = 1'b1; wait_q(); wait_q(); scl_m = 1'b0; wait_q();
        end
        sda_m = 1'b1; wait_q();
        chk("R5 before ack high", va, old_v);
        scl_m = 1'b1; wait_q(); wait_q();
        chk("R5 late in ack high", va, old_v);
        scl_m = 1'b0; wait_q();
        chk("R5 after ack fall", va, b);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic nack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q(); scl_m = 1'b1; wait_q(); b[i] = sda_line; wait_q(); scl_m = 1'b0; wait_q();
        end
        sda_m = nack; wait_q(); scl_m = 1'b1; wait_q(); wait_q(); scl_m = 1'b0; wait_q();
    endtask

    task automatic reg_write(input logic [7:0] rb, input logic [7:0] d, output logic ok);
        logic a1, a2, a3;
        bus_start();
        send_byte(8'h80, a1); send_byte(rb, a2); send_byte(d, a3);
        bus_stop();
        ok = a1 & a2 & a3;
        m_write(rb, d);
    endtask

    task automatic reg_read(input logic [7:0] rb, output logic [7:0] d, output logic ok);
        logic a1, a2, a3;
        bus_start();
        send_byte(8'h80, a1); send_byte(rb, a2);
        bus_start();
        send_byte(8'h81, a3);
        recv_byte(d, 1'b1);
        bus_stop();
        ok = a1 & a2 & a3;
    endtask

    task automatic read_cmp(input string tag, input logic [7:0] rb);
        logic [7:0] d, e;
        logic ok;
        e = m_peek(rb);
        reg_read(rb, d, ok);
        if (rb[2:0] == 3'd5) begin m_th = 1'b0; m_pg = 1'b0; end
        chk({tag, " ack"}, {7'b0, ok}, 8'h01);
        chk(tag, d, e);
    endtask

    task automatic outs_cmp(input string tag);
        chk({tag, " vout_a"}, va, m_va);
        chk({tag, " vout_b"}, vb, m_vb);
        chk({tag, " ctrl"}, ctrl, m_ctrl);
    endtask

    task automatic pulse(input bit th, input bit pg);
        @(negedge clk); therm = th; pgbad = pg;
        @(negedge clk); therm = 1'b0; pgbad = 1'b0;
        if (th) m_th = 1'b1;
        if (pg) m_pg = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic ok, a;
        logic [7:0] d;
        void'($urandom(32'h5EED_0042));
        m_defaults();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        outs_cmp("R1 reset");
        chk("R1 sda released", {7'b0, sda_oe}, 8'h00);
        read_cmp("R1 read status", 8'h05);
        read_cmp("R1 read vout_a", 8'h01);

        // R3 write and R4 read back
        reg_write(8'h01, 8'h5C, ok);
        chk("R3 write acks", {7'b0, ok}, 8'h01);
        outs_cmp("R3 after write");
        read_cmp("R4 read vout_a", 8'h01);

        // R4 aliasing on bits [2:0]
        reg_write(8'h0A, 8'h77, ok);
        outs_cmp("R4 alias write");
        read_cmp("R4 alias read", 8'hF2);

        // R6 unmapped indices and status not writable
        reg_write(8'h04, 8'hFF, ok);
        reg_write(8'h05, 8'hFF, ok);
        outs_cmp("R6 no effect");
        read_cmp("R6 index 4", 8'h04);
        read_cmp("R6 index 0", 8'h00);
        read_cmp("R6 index 7", 8'h07);
        read_cmp("R6 status after write", 8'h05);

        // R7 sticky flags, clear on read
        pulse(1'b1, 1'b0);
        repeat (20) @(negedge clk);
        read_cmp("R7 thermal set", 8'h05);
        read_cmp("R7 cleared", 8'h05);
        pulse(1'b1, 1'b1);
        read_cmp("R7 both set", 8'h05);
        pulse(1'b0, 1'b1);
        read_cmp("R7 power-bad set", 8'h05);

        // R5 commit timing
        bus_start();
        send_byte(8'h80, a); send_byte(8'h01, a);
        send_probe(8'hA3, m_va);
        bus_stop();
        m_write(8'h01, 8'hA3);

        // R2 wrong address ignored
        bus_start();
        send_byte(8'h82, a);
        chk("R2 wrong address nack", {7'b0, a}, 8'h00);
        send_byte(8'h01, a);
        send_byte(8'h11, a);
        bus_stop();
        outs_cmp("R2 no effect");

        // R9 byte without START after STOP
        send_byte(8'h80, a);
        chk("R9 no ack without start", {7'b0, a}, 8'h00);
        bus_stop();
        chk("R9 sda released", {7'b0, sda_oe}, 8'h00);

        // R8 control bit 7
        reg_write(8'h03, 8'h15, ok);
        read_cmp("R8 ctrl write", 8'h03);
        pulse(1'b1, 1'b1);
        reg_write(8'h03, 8'h80, ok);
        outs_cmp("R8 soft reset");
        read_cmp("R8 status cleared", 8'h05);
        read_cmp("R8 ctrl bit7 zero", 8'h03);

        // random mix
        for (int n = 0; n < 24; n++) begin
            logic [7:0] rb, dv;
            int op;
            op = $urandom % 4;
            rb = {$urandom % 32, 3'($urandom % 8)};
            dv = 8'($urandom);
            if (rb[2:0] == 3'd3 && ($urandom % 4) != 0) dv[7] = 1'b0;
            if (op == 0) pulse(($urandom % 2) == 1, ($urandom % 2) == 1);
            if (op <= 1) begin
                reg_write(rb, dv, ok);
                chk("R3 random write acks", {7'b0, ok}, 8'h01);
                outs_cmp("R3 random outputs");
            end else begin
                read_cmp("R4 random read", rb);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule